// File: doc/BRIEF.md
# Level-Crossing Event Timestamper and Serial Packetizer

This block sits behind an eight-stage level-crossing analog front-end. Its eight comparator outputs arrive asynchronously to the core clock and together form an 8-bit level code. The block brings the code into the clock domain and notices every change. It then waits until the code has been steady for a programmable settling time, which lets the later pipeline stages resolve. After that wait it accepts the code as one event.

Each accepted event carries a stamp taken from a free-running 32-bit cycle counter. It also carries one value byte. In direct mode the value byte is the settled code itself. In delta mode it is a direction bit plus the size of the change since the last reported code. Events wait in a small queue and leave the block as 5-byte packets on an 8N1 serial line. When the queue is full, new events are discarded and a sticky flag is raised.

Top module: `lcTimestamper`

## Requirements
- R1: `cmpIn[7]` is the first pipeline stage and the MSB of the level code, and `cmpIn[0]` is the LSB. In direct mode (`deltaMode`=0) the value byte equals the settled code, bit for bit.
- R2: The code is accepted only after the synchronized code has held unchanged for `SETTLE_CYC` consecutive cycles. Any change before that restarts the wait, so a burst of changes yields at most one event, carrying the final code.
- R3: The stamp is the count of clock edges since reset release at the cycle of acceptance. For an input change driven between edge n and edge n+1 that then holds, the stamp is n + `SETTLE_CYC` + 2.
- R4: Every event leaves as exactly 5 bytes: stamp bits 31:24, 23:16, 15:8 and 7:0, then the value byte.
- R5: In delta mode (`deltaMode`=1) the value byte is {up, magnitude}. Bit 7 is 1 when the code rose and 0 when it fell. Bits 6:0 hold |new − reference|, saturated at 127.
- R6: The reference is the code of the last queued event. The first event after reset is always queued, and in delta mode its value byte is 0x00. An accepted code equal to the reference produces no packet.
- R7: The queue holds `FIFO_DEPTH` events. An event that finds the queue full is dropped and does not move the reference. `overflow` then goes high and stays high until reset.
- R8: Each byte goes out as one low start bit, 8 data bits LSB first and one high stop bit. Every bit lasts `CLK_HZ`/`BAUD` cycles, and the line idles high.
- R9: During and right after reset, `txd` is high, `overflow` is low and no packet is sent while the inputs stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpIn | input | 8 | Asynchronous comparator outputs, bit 7 = first stage |
| deltaMode | input | 1 | 1 = delta value byte, 0 = direct code byte |
| txd | output | 1 | Serial 8N1 output, idle high |
| overflow | output | 1 | Sticky flag: an event was dropped because the queue was full |

## Verification
A wrong settle counter shows up in the stamp of the very next packet. An early or late acceptance shifts the stamp by the same number of cycles, and a missed restart adds a second packet carrying the glitch code. A corrupted reference only shows in the value byte of the following delta-mode event, so the sequences chain several deltas and place one right after a dropped event. Queue faults appear about one packet time later, as a missing, repeated or reordered packet, or as `overflow` rising too early or too late inside a burst.

// File: rtl/lcPkg.sv
package lcPkg;
  typedef struct packed {
    logic       accept;    // settled code is taken this cycle
    logic       pop;       // move queue head into the packet register
    logic       loadByte;  // load the selected byte into the serial shifter
    logic       shiftBit;  // advance the serial shifter by one bit
    logic [2:0] byteSel;   // packet byte being sent, 0 = stamp MSB
  } lcCtrl_t;
endpackage

// File: rtl/lcDatapath.sv
module lcDatapath #(
  parameter int TS_W       = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int PKT_BYTES  = 5,
  parameter int CNT_W      = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      cmpIn,
  input  logic            deltaMode,
  input  lcPkg::lcCtrl_t  ctrl,
  output logic            codeChange,
  output logic            fifoEmpty,
  output logic [CNT_W-1:0] fifoCount,
  output logic            overflow,
  output logic            txd
);
  localparam int ENT_W = TS_W + 8;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [7:0]      syncA, syncB, codeD, refCode;
  logic            haveRef;
  logic [TS_W-1:0] tsCnt;
  logic [ENT_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [ENT_W-1:0] pktReg;
  logic [9:0]      shiftReg;

  // two-flop synchronizer plus one delayed copy for change detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; codeD <= '0;
    end else begin
      syncA <= cmpIn; syncB <= syncA; codeD <= syncB;
    end
  end
  assign codeChange = (syncB != codeD);

  // value byte
  logic       goingUp;
  logic [7:0] absDiff, valByte;
  logic [6:0] mag;
  always_comb begin
    goingUp = syncB > refCode;
    absDiff = goingUp ? (syncB - refCode) : (refCode - syncB);
    mag     = absDiff[7] ? 7'h7F : absDiff[6:0];
    if (!deltaMode)   valByte = syncB;
    else if (!haveRef) valByte = 8'h00;
    else              valByte = {goingUp, mag};
  end

  logic fifoFull, isEvent, push;
  assign fifoFull  = (fifoCount == CNT_W'(FIFO_DEPTH));
  assign fifoEmpty = (fifoCount == '0);
  assign isEvent   = ctrl.accept && (!haveRef || (syncB != refCode));
  assign push      = isEvent && !fifoFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt <= '0; refCode <= '0; haveRef <= 1'b0; overflow <= 1'b0;
      wrPtr <= '0; rdPtr <= '0; fifoCount <= '0; pktReg <= '0;
    end else begin
      tsCnt <= tsCnt + 1'b1;
      if (isEvent && fifoFull) overflow <= 1'b1;
      if (push) begin
        refCode <= syncB;
        haveRef <= 1'b1;
        wrPtr   <= (wrPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : wrPtr + 1'b1;
      end
      if (ctrl.pop) begin
        pktReg <= mem[rdPtr];
        rdPtr  <= (rdPtr == PTR_W'(FIFO_DEPTH-1)) ? '0 : rdPtr + 1'b1;
      end
      fifoCount <= fifoCount + CNT_W'(push) - CNT_W'(ctrl.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {tsCnt, valByte};
  end

  // byte selection, most significant stamp byte first
  logic [7:0] pktBytes [PKT_BYTES];
  logic [7:0] curByte;
  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_bytes
    assign pktBytes[g] = pktReg[(PKT_BYTES-1-g)*8 +: 8];
  end
  always_comb begin
    curByte = 8'hFF;
    for (int i = 0; i < PKT_BYTES; i++)
      if (ctrl.byteSel == 3'(i)) curByte = pktBytes[i];
  end

  // serial shifter: stop, data LSB first, start
  always_ff @(posedge clk) begin
    if (!rstN)              shiftReg <= '1;
    else if (ctrl.loadByte) shiftReg <= {1'b1, curByte, 1'b0};
    else if (ctrl.shiftBit) shiftReg <= {1'b1, shiftReg[9:1]};
  end
  assign txd = shiftReg[0];
endmodule

// File: rtl/lcControl.sv
module lcControl #(
  parameter int SETTLE_CYC = 40,
  parameter int BAUD_DIV   = 108,
  parameter int PKT_BYTES  = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           codeChange,
  input  logic           fifoEmpty,
  output lcPkg::lcCtrl_t ctrl
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int DIV_W = $clog2(BAUD_DIV + 1);

  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_BIT} txState_t;

  txState_t   state;
  logic       settling;
  logic [SET_W-1:0] setCnt;
  logic [DIV_W-1:0] baudCnt;
  logic [3:0] bitIdx;
  logic [2:0] byteIdx;
  logic       bitEnd;

  always_comb begin
    bitEnd        = (state == TX_BIT) && (baudCnt == DIV_W'(BAUD_DIV-1));
    ctrl.accept   = settling && !codeChange && (setCnt == SET_W'(SETTLE_CYC-1));
    ctrl.pop      = (state == TX_IDLE) && !fifoEmpty;
    ctrl.loadByte = (state == TX_LOAD);
    ctrl.shiftBit = bitEnd && (bitIdx != 4'd9);
    ctrl.byteSel  = byteIdx;
  end

  // settle timer: restarts on every change of the synchronized code
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settling <= 1'b0; setCnt <= '0;
    end else if (codeChange) begin
      settling <= 1'b1; setCnt <= '0;
    end else if (settling) begin
      if (setCnt == SET_W'(SETTLE_CYC-1)) settling <= 1'b0;
      else setCnt <= setCnt + 1'b1;
    end
  end

  // packet sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= TX_IDLE; baudCnt <= '0; bitIdx <= '0; byteIdx <= '0;
    end else begin
      case (state)
        TX_IDLE: if (!fifoEmpty) begin
          state <= TX_LOAD; byteIdx <= '0;
        end
        TX_LOAD: begin
          state <= TX_BIT; bitIdx <= '0; baudCnt <= '0;
        end
        default: begin
          if (bitEnd) begin
            baudCnt <= '0;
            if (bitIdx == 4'd9) begin
              if (byteIdx == 3'(PKT_BYTES-1)) state <= TX_IDLE;
              else begin
                byteIdx <= byteIdx + 1'b1; state <= TX_LOAD;
              end
            end else bitIdx <= bitIdx + 1'b1;
          end else baudCnt <= baudCnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcTimestamper.sv
module lcTimestamper #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int BAUD       = 921_600,
  parameter int SETTLE_CYC = 40,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cmpIn,
  input  logic       deltaMode,
  output logic       txd,
  output logic       overflow
);
  localparam int TS_W      = 32;
  localparam int PKT_BYTES = (TS_W + 8) / 8;
  localparam int BAUD_DIV  = CLK_HZ / BAUD;
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);

  lcPkg::lcCtrl_t   ctrl;
  logic             codeChange, fifoEmpty;
  logic [CNT_W-1:0] fifoCount;

  lcDatapath #(.TS_W(TS_W), .FIFO_DEPTH(FIFO_DEPTH), .PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .deltaMode(deltaMode), .ctrl(ctrl),
    .codeChange(codeChange), .fifoEmpty(fifoEmpty), .fifoCount(fifoCount),
    .overflow(overflow), .txd(txd));

  lcControl #(.SETTLE_CYC(SETTLE_CYC), .BAUD_DIV(BAUD_DIV), .PKT_BYTES(PKT_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .codeChange(codeChange), .fifoEmpty(fifoEmpty), .ctrl(ctrl));
endmodule

// File: rtl/lcTimestamperChk.sv
module lcTimestamperChk #(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             txd,
  input logic             overflow,
  input lcPkg::lcCtrl_t   ctrl,
  input logic             codeChange,
  input logic [CNT_W-1:0] fifoCount
);
  // R7: dropped-event flag never clears on its own
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R7: occupancy stays within the queue depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(FIFO_DEPTH));
  // R2: acceptance never coincides with a code change
  a_r2_accept_stable: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accept |-> !codeChange);
  // R2: a change restarts the wait, so no acceptance right after it
  a_r2_restart: assert property (@(posedge clk) disable iff (!rstN)
    codeChange |=> !ctrl.accept);
  // R8: the sequencer only takes an entry that exists
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |-> (fifoCount != '0));
  // R8: a byte is loaded only while the line rests high
  a_r8_line_high_at_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadByte |-> txd);
  // R8: sequencer strobes are mutually exclusive
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.pop, ctrl.loadByte, ctrl.shiftBit}));
  // R9: on leaving reset the line is idle and the flag is clear
  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (txd && !overflow));
endmodule

bind lcTimestamper lcTimestamperChk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .txd(txd), .overflow(overflow), .ctrl(ctrl),
  .codeChange(codeChange), .fifoCount(fifoCount));

// File: tb/lcTimestamper_bench.sv
`timescale 1ns/1ps
module lcTimestamper_bench;
  localparam int CLK_HZ = 16, BAUD = 1, SETTLE = 20, DEPTH = 4;
  localparam int DIV = CLK_HZ / BAUD;

  logic clk = 1'b0, rstN = 1'b0, deltaMode = 1'b0;
  logic [7:0] cmpIn = 8'h00;
  logic txd, overflow;

  always #2.5 clk = ~clk;

  lcTimestamper #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .SETTLE_CYC(SETTLE), .FIFO_DEPTH(DEPTH)) u_lcTimestamper (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .deltaMode(deltaMode), .txd(txd), .overflow(overflow));

  typedef struct { logic [31:0] ts; logic [7:0] val; string tag; } exp_t;
  exp_t expQ[$];
  int checks = 0, fails = 0;
  logic [31:0] cyc;
  logic [7:0] refCode = 8'h00;
  bit haveRef = 1'b0;

  always_ff @(posedge clk) if (!rstN) cyc <= '0; else cyc <= cyc + 1;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: apply a code, predict its packet, push it to the scoreboard
  task automatic emit(logic [7:0] code, bit expectDrop, int waitCyc, string tag);
    exp_t e;
    int d;
    @(negedge clk);
    cmpIn = code;
    e.ts = cyc + SETTLE + 2;
    e.tag = tag;
    if (!haveRef || code != refCode) begin
      if (!deltaMode) e.val = code;
      else if (!haveRef) e.val = 8'h00;
      else begin
        d = int'(code) - int'(refCode);
        if (d > 0) e.val = {1'b1, (d > 127) ? 7'h7F : 7'(d)};
        else e.val = {1'b0, (-d > 127) ? 7'h7F : 7'(-d)};
      end
      if (!expectDrop) begin
        expQ.push_back(e);
        refCode = code;
        haveRef = 1'b1;
      end
    end
    repeat (waitCyc) @(negedge clk);
  endtask

  task automatic rxByte(output logic [7:0] b);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (DIV/2) @(negedge clk);
    check(txd === 1'b0, "R8 start bit", 64'(txd), 64'h0);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txd;
    end
    repeat (DIV) @(negedge clk);
    check(txd === 1'b1, "R8 stop bit", 64'(txd), 64'h1);
  endtask

  // monitor: decode packets and compare against the scoreboard
  initial begin
    logic [7:0] bytes [5];
    exp_t e;
    forever begin
      for (int k = 0; k < 5; k++) rxByte(bytes[k]);
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected packet", {24'h0, bytes[0], bytes[1], bytes[2], bytes[3], bytes[4]}, 64'h0);
      end else begin
        e = expQ.pop_front();
        check({bytes[0], bytes[1], bytes[2], bytes[3]} === e.ts,
              {"R3 R4 stamp ", e.tag}, 64'({bytes[0], bytes[1], bytes[2], bytes[3]}), 64'(e.ts));
        check(bytes[4] === e.val, {"value ", e.tag}, 64'(bytes[4]), 64'(e.val));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R9 txd idle in reset", 64'(txd), 64'h1);
    rstN = 1'b1;
    @(negedge clk);
    check(overflow === 1'b0, "R9 overflow clear", 64'(overflow), 64'h0);
    repeat (60) @(negedge clk);
    check(txd === 1'b1, "R9 no packet with quiet inputs", 64'(txd), 64'h1);

    deltaMode = 1'b1;
    emit(8'h40, 1'b0, 900, "R6 first event zero delta");
    emit(8'h41, 1'b0, 900, "R5 up by one");
    emit(8'h3E, 1'b0, 900, "R5 down by three");
    emit(8'hF0, 1'b0, 900, "R5 saturate up");
    emit(8'h05, 1'b0, 900, "R5 saturate down");
    // R2: glitch inside the settle window restarts the wait
    @(negedge clk); cmpIn = 8'h20;
    repeat (10) @(negedge clk);
    emit(8'h30, 1'b0, 900, "R2 restart keeps final code");
    // R6: excursion that returns to the reference gives no packet
    @(negedge clk); cmpIn = 8'h31;
    repeat (8) @(negedge clk);
    emit(8'h30, 1'b0, 900, "R6 no net change");

    deltaMode = 1'b0;
    emit(8'hA5, 1'b0, 900, "R1 direct code A5");
    emit(8'h01, 1'b0, 900, "R1 direct code LSB");

    // R7: burst fills the queue while the line is busy
    emit(8'h10, 1'b0, SETTLE + 6, "R7 burst 1");
    emit(8'h11, 1'b0, SETTLE + 6, "R7 burst 2");
    emit(8'h12, 1'b0, SETTLE + 6, "R7 burst 3");
    emit(8'h13, 1'b0, SETTLE + 6, "R7 burst 4");
    emit(8'h14, 1'b0, SETTLE + 6, "R7 burst 5");
    check(overflow === 1'b0, "R7 no overflow before full", 64'(overflow), 64'h0);
    emit(8'h15, 1'b1, SETTLE + 10, "R7 dropped");
    check(overflow === 1'b1, "R7 overflow on drop", 64'(overflow), 64'h1);
    repeat (5200) @(negedge clk);

    deltaMode = 1'b1;
    emit(8'h16, 1'b0, 1000, "R7 drop leaves reference");
    check(overflow === 1'b1, "R7 overflow sticky", 64'(overflow), 64'h1);
    check(expQ.size() == 0, "R4 all packets delivered", 64'(expQ.size()), 64'h0);
    check(txd === 1'b1, "R8 line idle after traffic", 64'(txd), 64'h1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule